// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one captured burst descriptor into the address of every beat of that burst. A descriptor holds a start address, a length field (beats minus one), a size field (the beat width is 2 to the power of this field, in bytes) and a burst kind. Once the block accepts a descriptor, it presents the address of the current beat. It moves to the next beat each time the data channel completes a handshake. It raises a last-beat flag on the final beat.

Three kinds are supported: a fixed address for every beat, a linear increment, and a wrapping sequence. The wrapping sequence stays inside an aligned window whose size is the beat width times the beat count. Descriptors that cannot be sequenced are rejected with an error flag and start no burst. Only one burst is in flight at a time: the descriptor port is ready only while the block is idle.

Top module: `burst_addr_gen`

## Requirements
- R1: `desc_ready` is high exactly when no burst is active. A descriptor is taken on a cycle where `desc_valid` and `desc_ready` are both high. A legal descriptor makes `beat_valid` high on the next cycle, with `beat_addr` equal to the start address. A `desc_valid` seen while a burst is active has no effect on the burst.
- R2: A burst has `desc_len`+1 beats. `beat_last` is high only on the final beat. The cycle after the final beat's handshake, `beat_valid` is low and `desc_ready` is high.
- R3: Kind 0 (fixed): every beat's address equals the start address.
- R4: Kind 1 (incrementing): each beat's address is the previous one plus 2^`desc_size` bytes, modulo 2^ADDR_W. For example, start 0x0, size 2 and length 3 give 0x0, 0x4, 0x8, 0xC.
- R5: Kind 2 (wrapping): let T = 2^size × (len+1). The window's low bound L is the start address rounded down to a multiple of T, and its high bound is L+T. The address advances by the beat width, and an address that would reach L+T becomes L instead.
- R6: The following descriptors are rejected:
  - kind 3;
  - a size field above BUS_LOG2;
  - a wrapping descriptor whose length field is not 1, 3, 7 or 15;
  - a wrapping descriptor whose start is not a multiple of the beat width.
  A rejected descriptor leaves `beat_valid` low and sets `wrap_err`.
- R7: `wrap_err` is low after reset. It holds its value until the next accepted descriptor, which sets it for an illegal descriptor and clears it for a legal one.
- R8: The beat address and beat index change only on a cycle with `beat_fire` high. While `beat_fire` is low, `beat_valid`, `beat_addr` and `beat_last` hold.
- R9: Reset (`rst_n` low, active low, synchronous to `clk`) ends any burst. After reset, `beat_valid` is low and `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Start address |
| desc_len | input | LEN_W | Beats minus one |
| desc_size | input | 3 | log2 of beat width in bytes |
| desc_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| beat_fire | input | 1 | Data-channel handshake for the current beat |
| beat_valid | output | 1 | A burst is active and beat_addr is meaningful |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| wrap_err | output | 1 | Last accepted descriptor was rejected |

## Verification
Each kind is run with several start offsets and beat widths, so that sequence errors show up:
- Wrapping windows of 2, 8 and 16 beats start in the middle of the window. A wrong low bound or fold point then gives a different address sequence.
- Incrementing bursts with byte-wide beats from an odd start, and a single beat at the top of the address space, separate the step width from any hidden alignment.
- One illegal descriptor of each reject class is followed by a legal one, which shows that the error flag both sets and clears.
- Stalls and a descriptor offered during a burst show that only the beat handshake moves the sequence.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

    localparam int SIZE_W = 3;

endpackage

// File: rtl/bag_desc_check.sv
module bag_desc_check
    import bag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 8,
    parameter int BUS_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  burst_kind_e       kind,
    output logic              bad
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    logic [ADDR_W-1:0] low_mask;
    logic              len_pow2;
    logic              len_high_zero;
    logic              misaligned;
    logic              size_bad;

    always_comb begin
        low_mask      = (ONE_A << size) - ONE_A;
        misaligned    = (addr & low_mask) != '0;
        len_high_zero = (len >> 4) == '0;
        // a 2..16 beat window: len+1 is a power of two and len is nonzero
        len_pow2      = (len[3:0] != 4'd0) && ((len[3:0] & (len[3:0] + 4'd1)) == 4'd0);
        size_bad      = 32'(size) > BUS_LOG2;
        bad           = size_bad || (kind == BK_RSVD)
                     || ((kind == BK_WRAP) && (!(len_pow2 && len_high_zero) || misaligned));
    end

endmodule

// File: rtl/bag_wrap_calc.sv
module bag_wrap_calc
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] lower,
    output logic [ADDR_W-1:0] upper
);
    logic [ADDR_W-1:0] beats;
    logic [ADDR_W-1:0] span;

    always_comb begin
        beats = ADDR_W'(len) + ADDR_W'(1);
        span  = beats << size;
        lower = addr & ~(span - ADDR_W'(1));
        upper = lower + span;
    end

endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  burst_kind_e       kind,
    input  logic [ADDR_W-1:0] cur,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] lower,
    input  logic [ADDR_W-1:0] upper,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] sum;

    always_comb begin
        sum = cur + (ADDR_W'(1) << size);
        unique case (kind)
            BK_FIXED: nxt = cur;
            BK_INCR:  nxt = sum;
            BK_WRAP:  nxt = (sum == upper) ? lower : sum;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 8,
    parameter int BUS_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [2:0]        desc_size,
    input  logic [1:0]        desc_kind,
    input  logic              beat_fire,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last,
    output logic              wrap_err
);
    typedef struct packed {
        logic              busy;
        logic              err;
        burst_kind_e       kind;
        logic [SIZE_W-1:0] size;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] lower;
        logic [ADDR_W-1:0] upper;
    } seq_state_t;

    seq_state_t st_d, st_q;

    burst_kind_e       in_kind;
    logic              in_bad;
    logic [ADDR_W-1:0] in_lower, in_upper;
    logic [ADDR_W-1:0] step_addr;
    logic              take;
    logic              at_last;

    assign in_kind = burst_kind_e'(desc_kind);

    bag_desc_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_LOG2(BUS_LOG2)) u_check (
        .addr (desc_addr),
        .len  (desc_len),
        .size (desc_size),
        .kind (in_kind),
        .bad  (in_bad)
    );

    bag_wrap_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_window (
        .addr  (desc_addr),
        .len   (desc_len),
        .size  (desc_size),
        .lower (in_lower),
        .upper (in_upper)
    );

    bag_next_addr #(.ADDR_W(ADDR_W)) u_step (
        .kind  (st_q.kind),
        .cur   (st_q.addr),
        .size  (st_q.size),
        .lower (st_q.lower),
        .upper (st_q.upper),
        .nxt   (step_addr)
    );

    always_comb begin
        st_d    = st_q;
        take    = desc_valid && !st_q.busy;
        at_last = st_q.cnt == st_q.len;
        if (take) begin
            st_d.err   = in_bad;
            st_d.busy  = !in_bad;
            st_d.kind  = in_kind;
            st_d.size  = desc_size;
            st_d.len   = desc_len;
            st_d.cnt   = '0;
            st_d.addr  = desc_addr;
            st_d.lower = in_lower;
            st_d.upper = in_upper;
        end else if (st_q.busy && beat_fire) begin
            if (at_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt  = st_q.cnt + LEN_W'(1);
                st_d.addr = step_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign desc_ready = !st_q.busy;
    assign beat_valid = st_q.busy;
    assign beat_addr  = st_q.addr;
    assign beat_last  = st_q.busy && at_last;
    assign wrap_err   = st_q.err;

    // R1: no descriptor port while a burst runs
    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !desc_ready);

    // R2: last flag only during an active burst
    p_last_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R2: handshake on the last beat ends the burst
    p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && beat_fire) |=> (!beat_valid && desc_ready));

    // R3: fixed bursts keep their address
    p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_fire && !beat_last && st_q.kind == BK_FIXED)
            |=> beat_addr == $past(beat_addr));

    // R4: incrementing bursts step by the beat width
    p_incr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_fire && !beat_last && st_q.kind == BK_INCR)
            |=> beat_addr == $past(beat_addr) + (ADDR_W'(1) << $past(st_q.size)));

    // R5: wrapping bursts stay inside their window
    p_wrap_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && st_q.kind == BK_WRAP)
            |-> (beat_addr >= st_q.lower && beat_addr < st_q.upper));

    // R8: a stalled beat holds
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_fire)
            |=> (beat_valid && $stable(beat_addr) && $stable(beat_last)));

endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] desc_addr = '0;
    logic [7:0]  desc_len = '0;
    logic [2:0]  desc_size = '0;
    logic [1:0]  desc_kind = '0;
    logic        beat_fire = 1'b0;
    logic        beat_valid;
    logic [31:0] beat_addr;
    logic        beat_last;
    logic        wrap_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(32), .LEN_W(8), .BUS_LOG2(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_len(desc_len),
        .desc_size(desc_size), .desc_kind(desc_kind),
        .beat_fire(beat_fire), .beat_valid(beat_valid),
        .beat_addr(beat_addr), .beat_last(beat_last), .wrap_err(wrap_err)
    );

    // fields: addr[45:14] len[13:6] size[5:3] kind[2:1] expect_err[0]
    localparam int NV = 12;
    localparam logic [45:0] VEC [NV] = '{
        {32'h0000_0000, 8'd3,  3'd2, 2'd1, 1'b0},  // R4 example
        {32'h0000_1000, 8'd2,  3'd2, 2'd0, 1'b0},  // R3
        {32'h0000_0038, 8'd3,  3'd2, 2'd2, 1'b0},  // R5 mid window
        {32'h0000_0104, 8'd7,  3'd1, 2'd2, 1'b0},  // R5
        {32'h0000_0040, 8'd2,  3'd2, 2'd2, 1'b1},  // R6 bad wrap length
        {32'h0000_0002, 8'd3,  3'd2, 2'd2, 1'b1},  // R6 misaligned wrap
        {32'h0000_0000, 8'd0,  3'd0, 2'd3, 1'b1},  // R6 reserved kind
        {32'h0000_0000, 8'd1,  3'd3, 2'd1, 1'b1},  // R6 size too wide
        {32'hFFFF_FFFC, 8'd0,  3'd2, 2'd1, 1'b0},  // R2 single beat, R7 clear
        {32'h0000_0007, 8'd4,  3'd0, 2'd1, 1'b0},  // R4 byte beats
        {32'h0000_002D, 8'd15, 3'd0, 2'd2, 1'b0},  // R5 sixteen beats
        {32'h0000_0044, 8'd1,  3'd2, 2'd2, 1'b0}   // R5 two beats
    };

    function automatic logic [31:0] model_addr(input logic [31:0] s, input int len,
                                               input int size, input int kind, input int i);
        logic [31:0] bytes, total, lower;
        bytes = 32'd1 << size;
        total = bytes * 32'(len + 1);
        case (kind)
            0: return s;
            1: return s + 32'(i) * bytes;
            default: begin
                lower = s - (s % total);
                return lower + ((s - lower + 32'(i) * bytes) % total);
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_burst(input logic [31:0] a, input int len, input int size,
                             input int kind, input bit exp_err, input bit stall);
        desc_valid = 1'b1; desc_addr = a; desc_len = 8'(len);
        desc_size = 3'(size); desc_kind = 2'(kind);
        check(desc_ready == 1'b1, "R1 ready before take", 32'(desc_ready), 32'd1);
        tick();
        desc_valid = 1'b0;
        check(wrap_err == exp_err, "R6/R7 error flag", 32'(wrap_err), 32'(exp_err));
        if (exp_err) begin
            check(beat_valid == 1'b0, "R6 rejected no burst", 32'(beat_valid), 32'd0);
            check(desc_ready == 1'b1, "R6 ready after reject", 32'(desc_ready), 32'd1);
            return;
        end
        for (int i = 0; i <= len; i++) begin
            check(beat_valid == 1'b1, "R1/R2 beat valid", 32'(beat_valid), 32'd1);
            check(beat_addr == model_addr(a, len, size, kind, i), "R3/R4/R5 beat address",
                  beat_addr, model_addr(a, len, size, kind, i));
            check(beat_last == (i == len), "R2 last flag", 32'(beat_last), 32'(i == len));
            if (stall && i == 1) begin
                tick();
                check(beat_addr == model_addr(a, len, size, kind, i), "R8 stall holds",
                      beat_addr, model_addr(a, len, size, kind, i));
                check(beat_valid == 1'b1, "R8 stall valid", 32'(beat_valid), 32'd1);
            end
            beat_fire = 1'b1;
            tick();
            beat_fire = 1'b0;
        end
        check(beat_valid == 1'b0, "R2 idle after last", 32'(beat_valid), 32'd0);
        check(desc_ready == 1'b1, "R2 ready after last", 32'(desc_ready), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        check(beat_valid == 1'b0, "R9 reset valid", 32'(beat_valid), 32'd0);
        check(desc_ready == 1'b1, "R9 reset ready", 32'(desc_ready), 32'd1);
        check(wrap_err == 1'b0, "R7 reset err", 32'(wrap_err), 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_burst(VEC[v][45:14], int'(VEC[v][13:6]), int'(VEC[v][5:3]),
                      int'(VEC[v][2:1]), VEC[v][0], (v % 2) == 0);
        end

        // R1: descriptor offered during a burst is ignored
        desc_valid = 1'b1; desc_addr = 32'h200; desc_len = 8'd3;
        desc_size = 3'd2; desc_kind = 2'd1;
        tick();
        desc_addr = 32'h900; desc_kind = 2'd0; desc_len = 8'd0;
        check(desc_ready == 1'b0, "R1 not ready while busy", 32'(desc_ready), 32'd0);
        beat_fire = 1'b1;
        tick();
        beat_fire = 1'b0;
        desc_valid = 1'b0;
        check(beat_addr == 32'h204, "R1 busy descriptor ignored", beat_addr, 32'h204);
        check(beat_last == 1'b0, "R1 length kept", 32'(beat_last), 32'd0);

        // R9: reset in the middle of a burst
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check(beat_valid == 1'b0, "R9 mid-burst reset valid", 32'(beat_valid), 32'd0);
        check(desc_ready == 1'b1, "R9 mid-burst reset ready", 32'(desc_ready), 32'd1);

        // R7: error flag persists while idle until the next descriptor
        run_burst(32'h3, 3, 2, 2, 1'b1, 1'b0);
        repeat (3) tick();
        check(wrap_err == 1'b1, "R7 error held", 32'(wrap_err), 32'd1);
        run_burst(32'h10, 1, 2, 0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule